// File: doc/BRIEF.md
# USB Host Root Port Control and Status Register

This block is the single control/status word for one USB host root port. Software reaches it through a plain write strobe with a data word and a read-data word. The port's link logic reaches it through event pulses (attach, detach, remote wakeup seen, bus reset finished), an overcurrent level, the two data-line levels and the detected device speed. In return the block drives the port's power switch, the bus-reset request, the suspend and resume requests and the test-pattern selector.

Software owns the control fields. The block owns the status fields and decides when the port becomes enabled and when it drops out of the enabled state. Three sticky change flags record events until software writes 1 to them. Line signalling, the timing of reset and resume, frame-start generation and PHY clock control are handled elsewhere. This block only holds state and requests.

Every field change caused by a write or an event takes effect at the next clock edge. `rd_data` is a registered copy of the register image, so it shows the change one edge later.

Top module: `hport_csr`

## Requirements
- R1: While reset is asserted, and on the first edge after it, every field, every `port_*` output and `rd_data` are 0.
- R2: Writes store bits 16:13 (test select), bit 12 (power) and bit 8 (bus reset), and read them back at the same positions. Bit 9, bit 0 and bits 31:19 always read 0. Writes to read-only fields have no effect.
- R3: Bit 10 reads the D+ level and bit 11 reads the D- level. Bits 18:17 read the device speed: 0 means high, 1 means full and 2 means low.
- R4: The test select field holds 0 (off), 1 (J), 2 (K), 3 (SE0/NAK), 4 (packet) or 5 (force enable). `port_test` always presents the stored code.
- R5: Bit 4 follows the overcurrent input. While overcurrent is present, power (bit 12) is cleared and cannot be written to 1. Bit 5 is set on every change of bit 4.
- R6: The enable bit (bit 2) is set only by a bus-reset-finished event. A write can never set it.
- R7: Enable is cleared by overcurrent, by detach, or by a write with bit 2 at 1. A clear beats a reset-finished event in the same cycle.
- R8: The enable change flag (bit 3) is set whenever the enable bit changes value.
- R9: Change flags (bits 1, 3, 5) clear only when software writes 1 to them. A set and a clear in the same cycle leave the flag at 1.
- R10: An attach event sets the connect flag (bit 1).
- R11: Writing bit 7 as 1 sets suspend, and writing it as 0 has no effect. Suspend is cleared by remote wakeup, by detach, or by a write that sets bit 8 or bit 6. A clear beats a set in the same write.
- R12: Resume (bit 6) follows writes. A remote wakeup sets it without software action. A detach clears it, and the detach has priority over the wakeup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered register image |
| lnk_connect | input | 1 | Device attach event pulse |
| lnk_disconnect | input | 1 | Device detach event pulse |
| lnk_overcurrent | input | 1 | Overcurrent level |
| lnk_wake | input | 1 | Remote wakeup detected pulse |
| lnk_reset_done | input | 1 | Bus reset sequence finished pulse |
| lnk_dp | input | 1 | D+ line level |
| lnk_dm | input | 1 | D- line level |
| lnk_speed | input | 2 | Detected device speed code |
| port_power | output | 1 | Port power switch request |
| port_reset | output | 1 | Bus reset request |
| port_suspend | output | 1 | Suspend state/request |
| port_resume | output | 1 | Resume signalling request |
| port_enabled | output | 1 | Port enabled state |
| port_test | output | 4 | Selected test pattern code |

## Verification
The assertions check several rules on every cycle. Power is never on in the cycle after overcurrent. Enable never rises without a reset-finished event and never survives an overcurrent. A change flag is set whenever enable or overcurrent-active moves, and a flag that is being set wins. Suspend falls after wakeup or detach, and resume rises after an undisturbed wakeup. Some behaviour can only be shown by the directed scenarios. These cover the bit positions and the encodings seen on `rd_data`, the refusal of writes to read-only and reserved bits, and the write-0-ignored rule for suspend. They also cover the same-cycle conflicts: reset-finished against detach, a write-1 clear against a hardware set, and a suspend write combined with reset or resume.

// File: rtl/hport_pkg.sv
package hport_pkg;
  // Bit positions that software decodes
  localparam int B_CONN   = 1;
  localparam int B_EN     = 2;
  localparam int B_ENCHG  = 3;
  localparam int B_OCACT  = 4;
  localparam int B_OCCHG  = 5;
  localparam int B_RES    = 6;
  localparam int B_SUSP   = 7;
  localparam int B_RST    = 8;
  localparam int B_LN_DP  = 10;
  localparam int B_LN_DM  = 11;
  localparam int B_PWR    = 12;
  localparam int B_TST_LO = 13;

  // Sticky change flag slots
  localparam int NFLAG   = 3;
  localparam int FL_CONN = 0;
  localparam int FL_EN   = 1;
  localparam int FL_OC   = 2;

  typedef enum logic [1:0] {SPD_HIGH = 2'd0, SPD_FULL = 2'd1, SPD_LOW = 2'd2} speed_e;
  typedef enum logic [3:0] {TM_OFF = 4'd0, TM_J = 4'd1, TM_K = 4'd2,
                            TM_SE0NAK = 4'd3, TM_PKT = 4'd4, TM_FORCE = 4'd5} test_e;
endpackage

// File: rtl/hport_flag.sv
module hport_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)      q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end

  AST_FLAG_SET_WINS: assert property (@(posedge clk) disable iff (rst) set |=> q); // R9
endmodule

// File: rtl/hport_link_stat.sv
module hport_link_stat (
  input  logic clk,
  input  logic rst,
  input  logic oc_in,
  input  logic disc,
  input  logic rdone,
  input  logic sw_dis,
  output logic oc_act,
  output logic en,
  output logic oc_chg,
  output logic en_chg
);
  logic en_nxt;

  always_comb begin
    if (oc_in || disc || sw_dis) en_nxt = 1'b0;
    else if (rdone)              en_nxt = 1'b1;
    else                         en_nxt = en;
  end

  assign en_chg = en_nxt != en;
  assign oc_chg = oc_in != oc_act;

  always_ff @(posedge clk) begin
    if (rst) begin
      en     <= 1'b0;
      oc_act <= 1'b0;
    end else begin
      en     <= en_nxt;
      oc_act <= oc_in;
    end
  end

  AST_EN_RISE_SRC: assert property (@(posedge clk) disable iff (rst) $rose(en) |-> $past(rdone)); // R6
  AST_EN_DROP_OC:  assert property (@(posedge clk) disable iff (rst) $past(oc_in) |-> !en);      // R7
endmodule

// File: rtl/hport_ctl.sv
module hport_ctl #(
  parameter int TEST_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [TEST_W-1:0] w_test,
  input  logic              w_pwr,
  input  logic              w_rst,
  input  logic              w_susp,
  input  logic              w_res,
  input  logic              oc_in,
  input  logic              disc,
  input  logic              wake,
  output logic [TEST_W-1:0] test,
  output logic              pwr,
  output logic              prst,
  output logic              susp,
  output logic              res
);
  logic susp_kill;
  assign susp_kill = wake || disc || (wr && (w_rst || w_res));

  always_ff @(posedge clk) begin
    if (rst) begin
      test <= '0;
      pwr  <= 1'b0;
      prst <= 1'b0;
      susp <= 1'b0;
      res  <= 1'b0;
    end else begin
      if (wr) test <= w_test;
      if (wr) prst <= w_rst;
      if (oc_in)   pwr <= 1'b0;
      else if (wr) pwr <= w_pwr;
      if (susp_kill)          susp <= 1'b0;
      else if (wr && w_susp)  susp <= 1'b1;
      if (disc)      res <= 1'b0;
      else if (wake) res <= 1'b1;
      else if (wr)   res <= w_res;
    end
  end

  AST_PWR_OFF_OC:   assert property (@(posedge clk) disable iff (rst) $past(oc_in) |-> !pwr);          // R5
  AST_SUSP_DROP:    assert property (@(posedge clk) disable iff (rst) $past(wake || disc) |-> !susp);  // R11
  AST_RES_ON_WAKE:  assert property (@(posedge clk) disable iff (rst) $past(wake && !disc) |-> res);    // R12
  AST_RES_DISC:     assert property (@(posedge clk) disable iff (rst) $past(disc) |-> !res);           // R12
endmodule

// File: rtl/hport_csr.sv
module hport_csr #(
  parameter int DATA_W = 32,
  parameter int TEST_W = 4,
  parameter int SPD_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              lnk_connect,
  input  logic              lnk_disconnect,
  input  logic              lnk_overcurrent,
  input  logic              lnk_wake,
  input  logic              lnk_reset_done,
  input  logic              lnk_dp,
  input  logic              lnk_dm,
  input  logic [SPD_W-1:0]  lnk_speed,
  output logic              port_power,
  output logic              port_reset,
  output logic              port_suspend,
  output logic              port_resume,
  output logic              port_enabled,
  output logic [TEST_W-1:0] port_test
);
  import hport_pkg::*;

  localparam int B_TST_HI = B_TST_LO + TEST_W - 1;
  localparam int B_SPD_LO = B_TST_HI + 1;
  localparam int B_SPD_HI = B_SPD_LO + SPD_W - 1;
  localparam int B_BITS_USED = B_SPD_HI + 1;

  logic [NFLAG-1:0] fl_set, fl_clr, fl_q;
  logic             oc_act, oc_chg, en_chg, sw_dis;
  logic [1:0]       line_q;
  logic [SPD_W-1:0] spd_q;
  logic [DATA_W-1:0] image;
  logic             unused_bits;

  assign unused_bits = ^{wr_data[DATA_W-1:B_SPD_LO], wr_data[B_LN_DM:B_LN_DP],
                         wr_data[B_OCACT], wr_data[B_RST+1], wr_data[0]};

  assign sw_dis = wr_en && wr_data[B_EN];

  hport_link_stat u_stat (
    .clk(clk), .rst(rst), .oc_in(lnk_overcurrent), .disc(lnk_disconnect),
    .rdone(lnk_reset_done), .sw_dis(sw_dis), .oc_act(oc_act), .en(port_enabled),
    .oc_chg(oc_chg), .en_chg(en_chg)
  );

  hport_ctl #(.TEST_W(TEST_W)) u_ctl (
    .clk(clk), .rst(rst), .wr(wr_en), .w_test(wr_data[B_TST_HI:B_TST_LO]),
    .w_pwr(wr_data[B_PWR]), .w_rst(wr_data[B_RST]), .w_susp(wr_data[B_SUSP]),
    .w_res(wr_data[B_RES]), .oc_in(lnk_overcurrent), .disc(lnk_disconnect),
    .wake(lnk_wake), .test(port_test), .pwr(port_power), .prst(port_reset),
    .susp(port_suspend), .res(port_resume)
  );

  assign fl_set[FL_CONN] = lnk_connect;
  assign fl_set[FL_EN]   = en_chg;
  assign fl_set[FL_OC]   = oc_chg;
  assign fl_clr[FL_CONN] = wr_en && wr_data[B_CONN];
  assign fl_clr[FL_EN]   = wr_en && wr_data[B_ENCHG];
  assign fl_clr[FL_OC]   = wr_en && wr_data[B_OCCHG];

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    hport_flag u_flag (.clk(clk), .rst(rst), .set(fl_set[g]), .clr(fl_clr[g]), .q(fl_q[g]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q <= '0;
      spd_q  <= '0;
    end else begin
      line_q <= {lnk_dm, lnk_dp};
      spd_q  <= lnk_speed;
    end
  end

  always_comb begin
    image                      = '0;
    image[B_CONN]              = fl_q[FL_CONN];
    image[B_EN]                = port_enabled;
    image[B_ENCHG]             = fl_q[FL_EN];
    image[B_OCACT]             = oc_act;
    image[B_OCCHG]             = fl_q[FL_OC];
    image[B_RES]               = port_resume;
    image[B_SUSP]              = port_suspend;
    image[B_RST]               = port_reset;
    image[B_LN_DP]             = line_q[0];
    image[B_LN_DM]             = line_q[1];
    image[B_PWR]               = port_power;
    image[B_TST_HI:B_TST_LO]   = port_test;
    image[B_SPD_HI:B_SPD_LO]   = spd_q;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= image;
  end

  initial begin
    if (B_BITS_USED > DATA_W) $error("register image does not fit DATA_W");
  end

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!port_power && !port_reset && !port_suspend && !port_resume && !port_enabled && port_test == '0)); // R1
  AST_ENCHG_TRACK: assert property (@(posedge clk) disable iff (rst)
    (port_enabled != $past(port_enabled)) |-> fl_q[FL_EN]); // R8
  AST_OCCHG_TRACK: assert property (@(posedge clk) disable iff (rst)
    (oc_act != $past(oc_act)) |-> fl_q[FL_OC]); // R5
  AST_NO_POWER_IN_OC: assert property (@(posedge clk) disable iff (rst)
    oc_act |-> !port_power); // R5
endmodule

// File: tb/sim_hport_csr.sv
module sim_hport_csr;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        lnk_connect = 0, lnk_disconnect = 0, lnk_overcurrent = 0, lnk_wake = 0, lnk_reset_done = 0;
  logic        lnk_dp = 0, lnk_dm = 0;
  logic [1:0]  lnk_speed = '0;
  logic        port_power, port_reset, port_suspend, port_resume, port_enabled;
  logic [3:0]  port_test;
  int          total = 0;
  int          bad = 0;

  always #10 clk = ~clk;

  hport_csr u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .lnk_connect(lnk_connect), .lnk_disconnect(lnk_disconnect), .lnk_overcurrent(lnk_overcurrent),
    .lnk_wake(lnk_wake), .lnk_reset_done(lnk_reset_done), .lnk_dp(lnk_dp), .lnk_dm(lnk_dm),
    .lnk_speed(lnk_speed), .port_power(port_power), .port_reset(port_reset),
    .port_suspend(port_suspend), .port_resume(port_resume), .port_enabled(port_enabled),
    .port_test(port_test)
  );

  localparam logic [3:0] EV_CONN = 4'b0001, EV_DISC = 4'b0010, EV_WAKE = 4'b0100, EV_RDONE = 4'b1000;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One cycle of events and/or write, then wait until rd_data reflects it
  task automatic drive(input logic [3:0] ev, input logic w, input logic [31:0] d);
    @(negedge clk);
    {lnk_reset_done, lnk_wake, lnk_disconnect, lnk_connect} = ev;
    wr_en = w;
    wr_data = d;
    @(negedge clk);
    {lnk_reset_done, lnk_wake, lnk_disconnect, lnk_connect} = '0;
    wr_en = 1'b0;
    wr_data = '0;
    @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] d);
    drive(4'b0, 1'b1, d);
  endtask

  task automatic settle();
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 rd_data", rd_data, 32'h0);
    chk("R1 outputs", {27'b0, port_power, port_reset, port_suspend, port_resume, port_enabled}, 32'h0);
    chk("R1 test", {28'b0, port_test}, 32'h0);
  endtask

  task automatic t_rw();
    wr(32'hFFFF_FFFF);
    chk("R2 all-ones write", rd_data, 32'h0001_F140);
    chk("R11 suspend cleared by reset write", {31'b0, port_suspend}, 32'h0);
    chk("R4 port_test", {28'b0, port_test}, 32'hF);
    wr(32'h0);
    chk("R2 zero write", rd_data, 32'h0);
  endtask

  task automatic t_line();
    lnk_dp = 1; lnk_dm = 0; settle();
    chk("R3 D+ bit10", rd_data, 32'h400);
    lnk_dp = 0; lnk_dm = 1; settle();
    chk("R3 D- bit11", rd_data, 32'h800);
    lnk_dm = 0; lnk_speed = 2'd2; settle();
    chk("R3 low speed", rd_data, 32'h0004_0000);
    lnk_speed = 2'd1; settle();
    chk("R3 full speed", rd_data, 32'h0002_0000);
    lnk_speed = 2'd0; settle();
    chk("R3 high speed", rd_data, 32'h0);
  endtask

  task automatic t_test();
    for (int m = 0; m < 6; m++) begin
      wr(32'(m) << 13);
      chk("R4 field", rd_data, 32'(m) << 13);
      chk("R4 port_test", {28'b0, port_test}, 32'(m));
    end
    wr(32'h0);
  endtask

  task automatic t_ovc();
    wr(32'h1000);
    chk("R2 power on", {31'b0, port_power}, 32'h1);
    lnk_overcurrent = 1; settle();
    chk("R5 oc raised", rd_data, 32'h30);
    wr(32'h1000);
    chk("R5 power blocked", rd_data, 32'h30);
    lnk_overcurrent = 0; settle();
    chk("R5 oc dropped", rd_data, 32'h20);
    wr(32'h20);
    chk("R9 oc flag cleared", rd_data, 32'h0);
  endtask

  task automatic t_enable();
    wr(32'h4);
    chk("R6 write cannot enable", rd_data, 32'h0);
    drive(EV_RDONE, 1'b0, 32'h0);
    chk("R6 enabled by reset done", rd_data, 32'hC);
    chk("R6 port_enabled", {31'b0, port_enabled}, 32'h1);
    wr(32'h8);
    chk("R9 en flag w1c", rd_data, 32'h4);
    wr(32'h4);
    chk("R7 sw disable", rd_data, 32'h8);
    wr(32'h8);
    drive(EV_RDONE, 1'b0, 32'h0);
    wr(32'h8);
    drive(EV_DISC, 1'b0, 32'h0);
    chk("R7 disconnect disables", rd_data, 32'h8);
    wr(32'h8);
    drive(EV_RDONE | EV_DISC, 1'b0, 32'h0);
    chk("R7 clear beats reset done", rd_data, 32'h0);
    drive(EV_RDONE, 1'b0, 32'h0);
    wr(32'hC);
    chk("R8 R9 change set wins over clear", rd_data, 32'h8);
    wr(32'h8);
    chk("R8 flag cleared", rd_data, 32'h0);
  endtask

  task automatic t_conn();
    drive(EV_CONN, 1'b0, 32'h0);
    chk("R10 connect flag", rd_data, 32'h2);
    wr(32'h2);
    chk("R9 connect w1c", rd_data, 32'h0);
    drive(EV_CONN, 1'b1, 32'h2);
    chk("R9 connect set wins", rd_data, 32'h2);
    wr(32'h2);
  endtask

  task automatic t_susp();
    wr(32'h80);
    chk("R11 suspend set", rd_data, 32'h80);
    wr(32'h0);
    chk("R11 write 0 ignored", rd_data, 32'h80);
    drive(EV_WAKE, 1'b0, 32'h0);
    chk("R11 R12 wake clears suspend sets resume", rd_data, 32'h40);
    wr(32'h0);
    wr(32'h80);
    drive(EV_DISC, 1'b0, 32'h0);
    chk("R11 disconnect clears suspend", rd_data, 32'h0);
    wr(32'h80);
    wr(32'h180);
    chk("R11 reset write clears suspend", rd_data, 32'h100);
    chk("R2 port_reset", {31'b0, port_reset}, 32'h1);
    wr(32'h0);
    wr(32'h80);
    wr(32'hC0);
    chk("R11 resume write clears suspend", rd_data, 32'h40);
    wr(32'h0);
  endtask

  task automatic t_res();
    wr(32'h40);
    chk("R12 resume written", {31'b0, port_resume}, 32'h1);
    drive(EV_DISC, 1'b0, 32'h0);
    chk("R12 disconnect clears", rd_data, 32'h0);
    drive(EV_WAKE | EV_DISC, 1'b0, 32'h0);
    chk("R12 disconnect beats wake", rd_data, 32'h0);
    drive(EV_WAKE, 1'b0, 32'h0);
    chk("R12 wake sets resume", rd_data, 32'h40);
    wr(32'h0);
    chk("R12 write clears resume", rd_data, 32'h0);
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    settle();
    t_reset();
    t_rw();
    t_line();
    t_test();
    t_ovc();
    t_enable();
    t_conn();
    t_susp();
    t_res();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule